// File: doc/BRIEF.md
# Revision-Configurable Address Decoder

This block sits between the 32-bit processor bus of an accelerator board and the board's memory targets. For every access it looks at the 32-bit address and the transfer size and names the single target that owns the access: the 24-bit legacy mainboard space, fast RAM, the expansion slot, the boot flash, the setup register page, the RAM controller page or the 24-bit shadow window. If no enabled target owns the access, the block raises a bus-error strobe instead. Accesses bound for the mainboard, directly or through the shadow window, also get their 24-bit mainboard address.

Three static straps shape the map. One picks the early or the late board generation. One moves fast RAM from a high base down to a low base. One says whether the fitted memory is 32 MB or 128 MB. The late generation drops the expansion slot and the upper flash mirror. The low-base variant no longer forwards the probe page to the mainboard. Boot software tells the variants apart by reading those probe addresses and noting which ones fault.

Every result is registered. It appears in the cycle after the address-valid strobe, lasts for exactly one cycle, and stays all-zero at any other time.

Top module: `addr_region_decoder`

## Requirements
- R1: An access whose address bits [31:24] are 0x00 selects the mainboard (select bit 0), and `mb_addr` carries address bits [23:0].
- R2: Fast RAM (select bit 1) starts at 0x04000000 when `strap_low_base` is 0 and at 0x01000000 when it is 1.
- R3: The fast-RAM window is 32 MB long. It is 128 MB long only when both `strap_late_gen` and `cfg_ram_large` are 1, so `cfg_ram_large` has no effect while `strap_late_gen` is 0. An access past the end of the window is a bus error.
- R4: Page 0xF0 through page 0xF3 selects the expansion slot (select bit 2) when `strap_late_gen` is 0. When `strap_late_gen` is 1 these pages are a bus error.
- R5: Page 0xF4 selects boot flash (select bit 3) on every variant. Page 0xF5 also selects flash when `strap_late_gen` is 0 and is a bus error when it is 1.
- R6: Page 0xF6 selects the setup registers (select bit 4). Page 0xF7 selects the RAM controller (select bit 5).
- R7: Page 0xFF selects the shadow window (select bit 6), and `mb_addr` carries address bits [23:0].
- R8: Page 0x0F is forwarded to the mainboard (select bit 0, `mb_addr` = address bits [23:0]) when `strap_low_base` is 0. When `strap_low_base` is 1 it is a bus error.
- R9: An access that no enabled target claims raises `bus_err`. In that case every select bit is 0 and `mb_addr` is 0. This covers pages 0x0C through 0x7F when they lie outside fast RAM, pages 0x80 through 0xEF, and pages 0xF8 through 0xFE.
- R10: The outputs are registered. They change one clock after an edge at which `req_valid` is 1 and hold for exactly one cycle. Otherwise the select bits, `bus_err` and `mb_addr` are 0, including during reset. At most one select bit or `bus_err` is high at a time.
- R11: `req_size` gives the access length: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 16 bytes. If the last byte falls in a different region from the first, the access is a bus error. The last-byte address wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_late_gen | input | 1 | Static strap: 1 selects the late board generation |
| strap_low_base | input | 1 | Static strap: 1 places fast RAM at the low base |
| cfg_ram_large | input | 1 | Static: 1 when 128 MB is fitted (honoured on the late generation only) |
| req_valid | input | 1 | Address-valid strobe |
| req_addr | input | 32 | Access address |
| req_size | input | 2 | Access length code |
| sel | output | 7 | One-hot region select |
| bus_err | output | 1 | Bus-error strobe |
| mb_addr | output | 24 | Translated mainboard address |

## Verification
The bench sweeps all 256 address pages under all eight strap combinations. For each page it uses three offsets and all four sizes, so it reaches the region edges where an access's last byte lands in the next page. A decoder that gated the flash mirror, the expansion slot or the probe page with the wrong strap would select a target where a fault belongs, or fault where a target belongs. The bench also checks that only the late generation honours the 128 MB setting and that the RAM window ends exactly at 32 MB or 128 MB above either base; a decoder that got this wrong would claim RAM that is not fitted. Long accesses that straddle 0x00FFFFFF or wrap past 0xFFFFFFFF must fault; a decoder that classified only the first byte would let them through. After every access an idle cycle is checked, which catches selects that linger for more than one cycle.

// File: rtl/addr_dec_pkg.sv
// Package: shared region codes and page constants for the address decoder.
// Assumes the map is laid out in 16 MB pages named by address bits [31:24].
package addr_dec_pkg;

    // Region codes; the numeric value is the select bit position.
    typedef enum logic [2:0] {
        RGN_MAIN   = 3'd0,
        RGN_FRAM   = 3'd1,
        RGN_EXP    = 3'd2,
        RGN_FLASH  = 3'd3,
        RGN_SETUP  = 3'd4,
        RGN_RCTL   = 3'd5,
        RGN_SHADOW = 3'd6,
        RGN_NONE   = 3'd7
    } region_e;

    localparam int NUM_RGN = 7;
    localparam int PAGE_W  = 8;

    localparam logic [PAGE_W-1:0] PG_MAIN     = 8'h00;
    localparam logic [PAGE_W-1:0] PG_PROBE    = 8'h0F;
    localparam logic [PAGE_W-1:0] PG_EXP_LO   = 8'hF0;
    localparam logic [PAGE_W-1:0] PG_EXP_HI   = 8'hF3;
    localparam logic [PAGE_W-1:0] PG_FLASH    = 8'hF4;
    localparam logic [PAGE_W-1:0] PG_FLASH_SH = 8'hF5;
    localparam logic [PAGE_W-1:0] PG_SETUP    = 8'hF6;
    localparam logic [PAGE_W-1:0] PG_RCTL     = 8'hF7;
    localparam logic [PAGE_W-1:0] PG_SHADOW   = 8'hFF;

endpackage

// File: rtl/access_span.sv
// Module: access_span
// Works out the address of the last byte touched by an access, from its start
// address and length code. Assumes the length codes 0/1/2/3 = 1/2/4/16 bytes.
// The sum wraps modulo 2^ADDR_W, so an access that wraps past the top of the
// address space lands in the bottom page.
module access_span #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 2
) (
    input  logic [ADDR_W-1:0] first_addr,
    input  logic [SIZE_W-1:0] size_code,
    output logic [ADDR_W-1:0] last_addr
);

    logic [ADDR_W-1:0] extent;

    // Purpose: map the length code to (bytes - 1).
    always_comb begin
        case (size_code)
            2'd0:    extent = ADDR_W'(0);
            2'd1:    extent = ADDR_W'(1);
            2'd2:    extent = ADDR_W'(3);
            default: extent = ADDR_W'(15);
        endcase
    end

    // Purpose: form the last-byte address with natural wrap.
    always_comb begin
        last_addr = first_addr + extent;
    end

endmodule

// File: rtl/region_classifier.sv
// Module: region_classifier
// Combinational decode of one address into a region code under the current
// straps. Assumes the straps are static while accesses are in flight. Fast RAM
// is matched by subtracting the strap-selected base and comparing the offset
// against the window length.
module region_classifier
    import addr_dec_pkg::*;
#(
    parameter int                ADDR_W        = 32,
    parameter logic [ADDR_W-1:0] RAM_BASE_HIGH = 32'h0400_0000,
    parameter logic [ADDR_W-1:0] RAM_BASE_LOW  = 32'h0100_0000,
    parameter int                RAM_SMALL_L2  = 25,
    parameter int                RAM_LARGE_L2  = 27
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              late_gen,
    input  logic              low_base,
    input  logic              ram_large,
    output region_e           rgn
);

    localparam int                PAGE_LSB    = ADDR_W - PAGE_W;
    localparam logic [ADDR_W:0]   SMALL_BYTES = (ADDR_W+1)'(1) << RAM_SMALL_L2;
    localparam logic [ADDR_W:0]   LARGE_BYTES = (ADDR_W+1)'(1) << RAM_LARGE_L2;

    logic [PAGE_W-1:0] page;
    logic [ADDR_W-1:0] ram_base;
    logic [ADDR_W:0]   ram_len;
    logic [ADDR_W:0]   ram_off;
    logic              ram_hit;

    // Purpose: pick the page index from the top address bits.
    always_comb begin
        page = addr[ADDR_W-1:PAGE_LSB];
    end

    // Purpose: choose RAM base and window length from straps.
    always_comb begin
        ram_base = low_base ? RAM_BASE_LOW : RAM_BASE_HIGH;
        ram_len  = (late_gen && ram_large) ? LARGE_BYTES : SMALL_BYTES;
    end

    // Purpose: window test; the borrow bit means addr lies below the base.
    always_comb begin
        ram_off = {1'b0, addr} - {1'b0, ram_base};
        ram_hit = !ram_off[ADDR_W] && (ram_off < ram_len);
    end

    // Purpose: priority decode of the address into a region code.
    always_comb begin
        rgn = RGN_NONE;
        if (page == PG_MAIN) begin
            rgn = RGN_MAIN;
        end else if (!low_base && page == PG_PROBE) begin
            rgn = RGN_MAIN;
        end else if (ram_hit) begin
            rgn = RGN_FRAM;
        end else if (page >= PG_EXP_LO && page <= PG_EXP_HI) begin
            rgn = late_gen ? RGN_NONE : RGN_EXP;
        end else begin
            case (page)
                PG_FLASH:    rgn = RGN_FLASH;
                PG_FLASH_SH: rgn = late_gen ? RGN_NONE : RGN_FLASH;
                PG_SETUP:    rgn = RGN_SETUP;
                PG_RCTL:     rgn = RGN_RCTL;
                PG_SHADOW:   rgn = RGN_SHADOW;
                default:     rgn = RGN_NONE;
            endcase
        end
    end

endmodule

// File: rtl/decode_outreg.sv
// Module: decode_outreg
// Registers the decode result. An access is claimed only when its first and
// last byte fall in the same enabled region. An unclaimed access raises the
// bus-error strobe instead. Every output returns to zero in any cycle that
// does not follow a valid strobe.
module decode_outreg
    import addr_dec_pkg::*;
#(
    parameter int MB_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid,
    input  region_e         rgn_first,
    input  region_e         rgn_last,
    input  logic [MB_W-1:0] low_addr,
    output logic [NUM_RGN-1:0] sel,
    output logic            bus_err,
    output logic [MB_W-1:0] mb_addr
);

    logic [NUM_RGN-1:0] onehot;
    logic               claimed;
    logic               to_main;

    // One select bit per region code.
    for (genvar i = 0; i < NUM_RGN; i++) begin : g_onehot
        assign onehot[i] = (rgn_first == region_e'(i));
    end

    // Purpose: decide whether the whole access lies in one enabled region.
    always_comb begin
        claimed = (rgn_first == rgn_last) && (rgn_first != RGN_NONE);
        to_main = (rgn_first == RGN_MAIN) || (rgn_first == RGN_SHADOW);
    end

    // Purpose: one-cycle registered select, error and translated address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel     <= '0;
            bus_err <= 1'b0;
            mb_addr <= '0;
        end else if (valid && claimed) begin
            sel     <= onehot;
            bus_err <= 1'b0;
            mb_addr <= to_main ? low_addr : '0;
        end else if (valid) begin
            sel     <= '0;
            bus_err <= 1'b1;
            mb_addr <= '0;
        end else begin
            sel     <= '0;
            bus_err <= 1'b0;
            mb_addr <= '0;
        end
    end

endmodule

// File: rtl/addr_region_decoder.sv
// Module: addr_region_decoder (top)
// Decodes each processor access into one board region, under static
// generation, RAM-placement and RAM-size straps. The first and the last byte
// of the access are classified by two identical classifiers, and the
// registered output stage merges the two results. Assumes the straps are
// static and that the request lasts one cycle.
module addr_region_decoder
    import addr_dec_pkg::*;
#(
    parameter int                ADDR_W        = 32,
    parameter int                SIZE_W        = 2,
    parameter int                MB_W          = 24,
    parameter logic [ADDR_W-1:0] RAM_BASE_HIGH = 32'h0400_0000,
    parameter logic [ADDR_W-1:0] RAM_BASE_LOW  = 32'h0100_0000,
    parameter int                RAM_SMALL_L2  = 25,
    parameter int                RAM_LARGE_L2  = 27
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strap_late_gen,
    input  logic               strap_low_base,
    input  logic               cfg_ram_large,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [SIZE_W-1:0]  req_size,
    output logic [NUM_RGN-1:0] sel,
    output logic               bus_err,
    output logic [MB_W-1:0]    mb_addr
);

    localparam int N_PROBE = 2;

    logic [ADDR_W-1:0] end_addr;
    logic [ADDR_W-1:0] probe_addr [N_PROBE];
    region_e           probe_rgn  [N_PROBE];

    access_span #(
        .ADDR_W (ADDR_W),
        .SIZE_W (SIZE_W)
    ) i_span (
        .first_addr (req_addr),
        .size_code  (req_size),
        .last_addr  (end_addr)
    );

    // Purpose: the two addresses to classify, first byte and last byte.
    always_comb begin
        probe_addr[0] = req_addr;
        probe_addr[1] = end_addr;
    end

    for (genvar k = 0; k < N_PROBE; k++) begin : g_cls
        region_classifier #(
            .ADDR_W        (ADDR_W),
            .RAM_BASE_HIGH (RAM_BASE_HIGH),
            .RAM_BASE_LOW  (RAM_BASE_LOW),
            .RAM_SMALL_L2  (RAM_SMALL_L2),
            .RAM_LARGE_L2  (RAM_LARGE_L2)
        ) i_cls (
            .addr      (probe_addr[k]),
            .late_gen  (strap_late_gen),
            .low_base  (strap_low_base),
            .ram_large (cfg_ram_large),
            .rgn       (probe_rgn[k])
        );
    end

    decode_outreg #(
        .MB_W (MB_W)
    ) i_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (req_valid),
        .rgn_first (probe_rgn[0]),
        .rgn_last  (probe_rgn[1]),
        .low_addr  (req_addr[MB_W-1:0]),
        .sel       (sel),
        .bus_err   (bus_err),
        .mb_addr   (mb_addr)
    );

endmodule

// File: rtl/addr_region_decoder_chk.sv
// Module: addr_region_decoder_chk
// Property checker for the decoder's port behaviour, bound to the top module.
module addr_region_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        strap_late_gen,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic [1:0]  req_size,
    input logic [6:0]  sel,
    input logic        bus_err,
    input logic [23:0] mb_addr
);

    assert_single_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel, bus_err}));

    assert_err_no_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (sel == 7'd0 && mb_addr == 24'd0));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (sel == 7'd0 && !bus_err && mb_addr == 24'd0));

    assert_valid_answers_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (sel != 7'd0 || bus_err));

    assert_no_exp_late_R4: assert property (@(posedge clk) disable iff (!rst_n)
        strap_late_gen |-> !sel[2]);

    assert_setup_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[31:24] == 8'hF6 && req_size == 2'd0) |=> sel[4]);

    assert_shadow_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[31:24] == 8'hFF && req_size == 2'd0)
        |=> (sel[6] && mb_addr == $past(req_addr[23:0])));

    assert_mb_addr_owner_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_addr != 24'd0) |-> (sel[0] || sel[6]));

endmodule

bind addr_region_decoder addr_region_decoder_chk i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .strap_late_gen (strap_late_gen),
    .req_valid      (req_valid),
    .req_addr       (req_addr),
    .req_size       (req_size),
    .sel            (sel),
    .bus_err        (bus_err),
    .mb_addr        (mb_addr)
);

// File: tb/test_addr_region_decoder.sv
`timescale 1ns/1ps
module test_addr_region_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_late_gen = 1'b0;
    logic        strap_low_base = 1'b0;
    logic        cfg_ram_large = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [6:0]  sel;
    logic        bus_err;
    logic [23:0] mb_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    addr_region_decoder i_addr_region_decoder (
        .clk            (clk),
        .rst_n          (rst_n),
        .strap_late_gen (strap_late_gen),
        .strap_low_base (strap_low_base),
        .cfg_ram_large  (cfg_ram_large),
        .req_valid      (req_valid),
        .req_addr       (req_addr),
        .req_size       (req_size),
        .sel            (sel),
        .bus_err        (bus_err),
        .mb_addr        (mb_addr)
    );

    // Region model from the requirements: 0..6 = select bit, 7 = unclaimed.
    function automatic int model_region(logic [31:0] a, bit lg, bit lb, bit big);
        logic [7:0]  pg;
        logic [31:0] base;
        logic [31:0] len;
        pg   = a[31:24];
        base = lb ? 32'h0100_0000 : 32'h0400_0000;
        len  = (lg && big) ? 32'h0800_0000 : 32'h0200_0000;
        if (pg == 8'h00) return 0;                      // R1
        if (!lb && pg == 8'h0F) return 0;               // R8
        if (a >= base && a < base + len) return 1;      // R2, R3
        if (pg >= 8'hF0 && pg <= 8'hF3) return lg ? 7 : 2;  // R4
        if (pg == 8'hF4) return 3;                      // R5
        if (pg == 8'hF5) return lg ? 7 : 3;             // R5
        if (pg == 8'hF6) return 4;                      // R6
        if (pg == 8'hF7) return 5;                      // R6
        if (pg == 8'hFF) return 6;                      // R7
        return 7;                                       // R9
    endfunction

    function automatic string req_tag(int r, bit span, logic [7:0] pg);
        if (span) return "R11";
        case (r)
            0: return (pg == 8'h0F) ? "R8" : "R1";
            1: return "R2";
            2: return "R4";
            3: return "R5";
            4, 5: return "R6";
            6: return "R7";
            default: return (pg < 8'h0C) ? "R3" : "R9";
        endcase
    endfunction

    task automatic check_out(string tag, logic [6:0] es, logic ee, logic [23:0] em);
        n_tests++;
        if (sel !== es || bus_err !== ee || mb_addr !== em) begin
            n_fail++;
            $display("FAIL %s addr=%h size=%0d straps=%b%b%b: sel=%b err=%b mb=%h expected sel=%b err=%b mb=%h",
                     tag, req_addr, req_size, strap_late_gen, strap_low_base, cfg_ram_large,
                     sel, bus_err, mb_addr, es, ee, em);
        end
    endtask

    // One access: drive after a falling edge, sample one cycle later, then an idle cycle.
    task automatic do_access(logic [31:0] a, logic [1:0] sz);
        int          r0;
        int          r1;
        logic [31:0] last;
        logic [31:0] ext;
        logic [6:0]  es;
        logic        ee;
        logic [23:0] em;
        ext  = (sz == 2'd0) ? 32'd0 : (sz == 2'd1) ? 32'd1 : (sz == 2'd2) ? 32'd3 : 32'd15;
        last = a + ext;
        r0 = model_region(a, strap_late_gen, strap_low_base, cfg_ram_large);
        r1 = model_region(last, strap_late_gen, strap_low_base, cfg_ram_large);
        if (r0 != 7 && r0 == r1) begin
            es = 7'(1 << r0);
            ee = 1'b0;
            em = (r0 == 0 || r0 == 6) ? a[23:0] : 24'd0;
        end else begin
            es = '0;
            ee = 1'b1;
            em = '0;
        end
        req_addr  = a;
        req_size  = sz;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check_out(req_tag(r0, (r0 != 7 && r0 != r1), a[31:24]), es, ee, em);
        @(negedge clk);
        check_out("R10", 7'd0, 1'b0, 24'd0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [23:0] offs [3];
        offs[0] = 24'h000000;
        offs[1] = 24'h7FFFF8;
        offs[2] = 24'hFFFFFE;

        // Reset state, R10: outputs zero while reset is held, even with valid high.
        req_valid = 1'b1;
        req_addr  = 32'hF600_0000;
        repeat (3) @(negedge clk);
        check_out("R10", 7'd0, 1'b0, 24'd0);
        req_valid = 1'b0;
        rst_n     = 1'b1;
        @(negedge clk);
        check_out("R10", 7'd0, 1'b0, 24'd0);

        // Full sweep over straps, pages, offsets and sizes (R1..R11).
        for (int s = 0; s < 8; s++) begin
            strap_late_gen = s[2];
            strap_low_base = s[1];
            cfg_ram_large  = s[0];
            @(negedge clk);
            for (int p = 0; p < 256; p++) begin
                for (int o = 0; o < 3; o++) begin
                    for (int z = 0; z < 4; z++) begin
                        do_access({p[7:0], offs[o]}, z[1:0]);
                    end
                end
            end
        end

        // Directed edges of the RAM window, R3: the last byte of 128 MB at the high base.
        strap_late_gen = 1'b1; strap_low_base = 1'b0; cfg_ram_large = 1'b1;
        @(negedge clk);
        do_access(32'h0BFF_FFFF, 2'd0);
        do_access(32'h0C00_0000, 2'd0);
        // Large setting ignored on early generation, R3.
        strap_late_gen = 1'b0;
        @(negedge clk);
        do_access(32'h05FF_FFFF, 2'd0);
        do_access(32'h0600_0000, 2'd0);
        // Wrap past the top of the address space, R11.
        do_access(32'hFFFF_FFFF, 2'd2);
        // Back-to-back valid strobes, R10: each result lasts one cycle.
        req_addr = 32'hF400_0000; req_size = 2'd0; req_valid = 1'b1;
        @(negedge clk);
        check_out("R10", 7'b0001000, 1'b0, 24'd0);
        req_addr = 32'h8000_0000;
        @(negedge clk);
        req_valid = 1'b0;
        check_out("R10", 7'd0, 1'b1, 24'd0);
        @(negedge clk);
        check_out("R10", 7'd0, 1'b0, 24'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule